// File: doc/BRIEF.md
# Banded Screen Interleave Compositor

This block merges the pixel streams of several render engines into one display raster. The screen is cut into horizontal bands of a programmable number of lines. The bands are dealt out to the engines in turn from the top of the screen, and the rotation restarts at engine 0 once the last active engine has had its band. For every pixel that the display asks for, the block picks the engine that owns the current line and pops one pixel from that engine's stream. It then forwards the pixel on a single digital output that marks the start of each line and of each frame.

A band height of one line with two engines gives plain even/odd scan-line interleave. Taller bands and more engines spread the work in wider strips. Band height and engine count come from configuration inputs that are captured only on the start-of-frame pulse. A frame therefore never changes its partition partway down. If the owning engine has no pixel ready, the block emits a fixed fill colour and sets a sticky underflow flag.

Top module: `band_interleave_mux`

## Requirements
- R1: After reset, out_valid, out_sol, out_sof, out_fill, underflow and every eng_ready bit are 0.
- R2: The band height is cfg_band_m1+1 lines (1 to 256) and the engine count is cfg_eng_m1+1 (1 to 32). The owner of frame line L is floor(L / height) mod count, with lines counted from 0 after the start-of-frame pulse and each line lasting LINE_PIX pixel requests.
- R3: With cfg_band_m1=0 and cfg_eng_m1=1, engine 0 supplies every even line and engine 1 supplies every odd line.
- R4: The configuration inputs are sampled only in a cycle with sof=1. Changing them at any other time has no effect on line ownership until the next sof.
- R5: A pixel request (pix_en=1, sof=0) produces out_valid=1 in the following cycle. If the owner's valid bit was 1, out_data then equals that owner's data from the request cycle. A cycle with no request produces out_valid=0 in the following cycle.
- R6: out_sol is 1 on the output of the first pixel of every line. out_sof is 1 on the output of the first pixel after a sof pulse. Both are 0 on all other output pixels.
- R7: If the owner's valid bit is 0 at a request, the output pixel carries the FILL colour with out_fill=1. The underflow output goes to 1 in the same cycle and stays 1 until reset.
- R8: eng_ready is 1 only for the current owner, and only in a cycle with pix_en=1 and sof=0. At all other times every bit is 0.
- R9: A sof pulse restarts the pixel and line counters and the rotation at engine 0, even partway through a frame. A pixel request in the same cycle as sof is ignored: no eng_ready and no output pixel.
- R10: After the last configured engine's band, ownership wraps back to engine 0. This holds at the full count of 32 engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse; captures configuration and restarts counters |
| pix_en | input | 1 | Display requests one pixel this cycle |
| cfg_band_m1 | input | 8 | Band height minus one |
| cfg_eng_m1 | input | 5 | Engine count minus one |
| eng_valid | input | N_ENG | Per-engine pixel available |
| eng_data | input | N_ENG*PIX_W | Per-engine pixel data, engine i at bits [i*PIX_W +: PIX_W] |
| eng_ready | output | N_ENG | Per-engine pop strobe |
| out_valid | output | 1 | Output pixel present |
| out_data | output | PIX_W | Output pixel |
| out_sol | output | 1 | Output pixel is first of a line |
| out_sof | output | 1 | Output pixel is first of a frame |
| out_fill | output | 1 | Output pixel is the fill colour |
| underflow | output | 1 | Sticky: a needed engine pixel was missing |

## Verification
The hardest case to reach from the ports is the step from the 256th line of a band to the first line of the next band at the largest band height. Reaching it takes hundreds of whole lines inside one frame. The bench shortens each line to four pixels through the line-length parameter and runs more than 256 lines at the maximum height. Ownership is checked on every pixel against a division-based reference. Configuration hold is reached by changing the inputs after sof, partway through a frame, and confirming that ownership keeps following the captured values.

// File: rtl/band_mux_pkg.sv
package band_mux_pkg;
    localparam int BAND_W = 8;
    localparam int IDX_W  = 5;
    typedef logic [BAND_W-1:0] band_t;
    typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/band_owner_track.sv
module band_owner_track
    import band_mux_pkg::*;
#(
    parameter int N_ENG    = 32,
    parameter int LINE_PIX = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic pix_en_i,
    input  band_t cfg_band_m1_i,
    input  idx_t  cfg_eng_m1_i,
    output idx_t  owner_o,
    output logic  sol_o,
    output logic  first_o
);
    localparam int PIX_CW = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
    localparam logic [PIX_CW-1:0] LAST_PIX = PIX_CW'(LINE_PIX - 1);
    localparam idx_t MAX_IDX = idx_t'(N_ENG - 1);

    typedef struct packed {
        logic [PIX_CW-1:0] pix;
        band_t             band;
        idx_t              own;
        band_t             band_m1;
        idx_t              eng_m1;
        logic              first;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (sof_i) begin
            trk_d.pix     = '0;
            trk_d.band    = '0;
            trk_d.own     = '0;
            trk_d.band_m1 = cfg_band_m1_i;
            trk_d.eng_m1  = (cfg_eng_m1_i > MAX_IDX) ? MAX_IDX : cfg_eng_m1_i;
            trk_d.first   = 1'b1;
        end else if (pix_en_i) begin
            trk_d.first = 1'b0;
            if (trk_q.pix == LAST_PIX) begin
                trk_d.pix = '0;
                if (trk_q.band == trk_q.band_m1) begin
                    trk_d.band = '0;
                    trk_d.own  = (trk_q.own == trk_q.eng_m1) ? '0 : trk_q.own + 1'b1;
                end else begin
                    trk_d.band = trk_q.band + 1'b1;
                end
            end else begin
                trk_d.pix = trk_q.pix + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q       <= '0;
            trk_q.first <= 1'b1;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign owner_o = trk_q.own;
    assign sol_o   = (trk_q.pix == '0);
    assign first_o = trk_q.first;
endmodule

// File: rtl/engine_select.sv
module engine_select
    import band_mux_pkg::*;
#(
    parameter int              N_ENG = 32,
    parameter int              PIX_W = 16,
    parameter logic [PIX_W-1:0] FILL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_en_i,
    input  logic                   sof_i,
    input  idx_t                   owner_i,
    input  logic                   sol_i,
    input  logic                   first_i,
    input  logic [N_ENG-1:0]       eng_valid_i,
    input  logic [N_ENG*PIX_W-1:0] eng_data_i,
    output logic [N_ENG-1:0]       eng_ready_o,
    output logic                   out_valid_o,
    output logic [PIX_W-1:0]       out_data_o,
    output logic                   out_sol_o,
    output logic                   out_sof_o,
    output logic                   out_fill_o,
    output logic                   underflow_o
);
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] data;
        logic             sol;
        logic             sof;
        logic             fill;
        logic             uflow;
    } out_t;

    out_t out_d, out_q;
    logic take;
    logic sel_valid;
    logic [PIX_W-1:0] sel_data;

    assign take = pix_en_i && !sof_i;

    for (genvar g = 0; g < N_ENG; g++) begin : g_ready
        assign eng_ready_o[g] = take && (owner_i == idx_t'(g));
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_data  = '0;
        for (int i = 0; i < N_ENG; i++) begin
            if (owner_i == idx_t'(i)) begin
                sel_valid = eng_valid_i[i];
                sel_data  = eng_data_i[i*PIX_W +: PIX_W];
            end
        end
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = take;
        out_d.sol   = 1'b0;
        out_d.sof   = 1'b0;
        out_d.fill  = 1'b0;
        if (take) begin
            out_d.sol = sol_i;
            out_d.sof = first_i;
            if (sel_valid) begin
                out_d.data = sel_data;
            end else begin
                out_d.data  = FILL;
                out_d.fill  = 1'b1;
                out_d.uflow = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid_o = out_q.valid;
    assign out_data_o  = out_q.data;
    assign out_sol_o   = out_q.sol;
    assign out_sof_o   = out_q.sof;
    assign out_fill_o  = out_q.fill;
    assign underflow_o = out_q.uflow;
endmodule

// File: rtl/band_interleave_mux.sv
module band_interleave_mux
    import band_mux_pkg::*;
#(
    parameter int               N_ENG    = 32,
    parameter int               PIX_W    = 16,
    parameter int               LINE_PIX = 640,
    parameter logic [PIX_W-1:0] FILL     = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sof,
    input  logic                   pix_en,
    input  logic [7:0]             cfg_band_m1,
    input  logic [4:0]             cfg_eng_m1,
    input  logic [N_ENG-1:0]       eng_valid,
    input  logic [N_ENG*PIX_W-1:0] eng_data,
    output logic [N_ENG-1:0]       eng_ready,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_data,
    output logic                   out_sol,
    output logic                   out_sof,
    output logic                   out_fill,
    output logic                   underflow
);
    idx_t owner;
    logic sol, first;

    band_owner_track #(.N_ENG(N_ENG), .LINE_PIX(LINE_PIX)) u_track (
        .clk(clk), .rst_n(rst_n), .sof_i(sof), .pix_en_i(pix_en),
        .cfg_band_m1_i(cfg_band_m1), .cfg_eng_m1_i(cfg_eng_m1),
        .owner_o(owner), .sol_o(sol), .first_o(first)
    );

    engine_select #(.N_ENG(N_ENG), .PIX_W(PIX_W), .FILL(FILL)) u_sel (
        .clk(clk), .rst_n(rst_n), .pix_en_i(pix_en), .sof_i(sof),
        .owner_i(owner), .sol_i(sol), .first_i(first),
        .eng_valid_i(eng_valid), .eng_data_i(eng_data),
        .eng_ready_o(eng_ready), .out_valid_o(out_valid), .out_data_o(out_data),
        .out_sol_o(out_sol), .out_sof_o(out_sof), .out_fill_o(out_fill),
        .underflow_o(underflow)
    );
endmodule

// File: rtl/band_mux_checks.sv
module band_mux_checks #(
    parameter int               N_ENG = 32,
    parameter int               PIX_W = 16,
    parameter logic [PIX_W-1:0] FILL  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             pix_en,
    input logic [N_ENG-1:0] eng_ready,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_data,
    input logic             out_sol,
    input logic             out_sof,
    input logic             out_fill,
    input logic             underflow
);
    assert_out_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(pix_en && !sof));

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    assert_fill_colour_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fill |-> (out_data == FILL && underflow && out_valid));

    assert_ready_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_ready));

    assert_ready_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ready != '0) |-> (pix_en && !sof));

    assert_frame_mark_on_line_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));
endmodule

bind band_interleave_mux band_mux_checks #(.N_ENG(N_ENG), .PIX_W(PIX_W), .FILL(FILL)) u_checks (
    .clk(clk), .rst_n(rst_n), .sof(sof), .pix_en(pix_en), .eng_ready(eng_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof),
    .out_fill(out_fill), .underflow(underflow)
);

// File: tb/band_interleave_mux_bench.sv
`timescale 1ns/1ps
module band_interleave_mux_bench;
    localparam int N_ENG = 32;
    localparam int PIX_W = 16;
    localparam int LINE_PIX = 4;
    localparam logic [PIX_W-1:0] FILL = 16'hF1F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0, pix_en = 1'b0;
    logic [7:0] cfg_band_m1 = '0;
    logic [4:0] cfg_eng_m1 = '0;
    logic [N_ENG-1:0] eng_valid = '1;
    logic [N_ENG*PIX_W-1:0] eng_data;
    logic [N_ENG-1:0] eng_ready;
    logic out_valid, out_sol, out_sof, out_fill, underflow;
    logic [PIX_W-1:0] out_data;

    int checks = 0, failures = 0;
    int ln = 0, px = 0, cb = 0, ce = 0;
    bit first_exp = 1'b1, uf_exp = 1'b0, done = 1'b0;

    always #2.5 clk = ~clk;

    band_interleave_mux #(.N_ENG(N_ENG), .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .FILL(FILL))
    u_band_interleave_mux (
        .clk(clk), .rst_n(rst_n), .sof(sof), .pix_en(pix_en),
        .cfg_band_m1(cfg_band_m1), .cfg_eng_m1(cfg_eng_m1),
        .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
        .out_sof(out_sof), .out_fill(out_fill), .underflow(underflow)
    );

    function automatic logic [PIX_W-1:0] eng_pix(int i);
        return (PIX_W'(i) << 8) | 16'h00C3;
    endfunction

    initial begin
        for (int i = 0; i < N_ENG; i++) eng_data[i*PIX_W +: PIX_W] = eng_pix(i);
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h (line %0d px %0d)", req, act, exp, ln, px);
        end
    endtask

    task automatic do_sof(int b, int e);
        @(negedge clk);
        sof = 1'b1; cfg_band_m1 = 8'(b); cfg_eng_m1 = 5'(e);
        @(negedge clk);
        sof = 1'b0;
        cb = b; ce = e; ln = 0; px = 0; first_exp = 1'b1;
    endtask

    // one requested pixel, checked against the division-based reference
    task automatic one_pixel(string req);
        int own;
        logic [PIX_W-1:0] exp_d;
        bit fill;
        own = (ln / (cb + 1)) % (ce + 1);
        @(negedge clk);
        pix_en = 1'b1;
        #1;
        chk(eng_ready === (32'd1 << own), {req, " R8 ready"}, eng_ready, 32'd1 << own);
        fill = !eng_valid[own];
        @(negedge clk);
        pix_en = 1'b0;
        exp_d = fill ? FILL : eng_pix(own);
        if (fill) uf_exp = 1'b1;
        chk(out_valid === 1'b1, {req, " R5 valid"}, out_valid, 1);
        chk(out_data === exp_d, {req, " R2 data"}, out_data, exp_d);
        chk(out_sol === (px == 0), {req, " R6 sol"}, out_sol, px == 0);
        chk(out_sof === first_exp, {req, " R6 sof"}, out_sof, first_exp);
        chk(out_fill === fill, {req, " R7 fill"}, out_fill, fill);
        chk(underflow === uf_exp, {req, " R7 underflow"}, underflow, uf_exp);
        first_exp = 1'b0;
        px++;
        if (px == LINE_PIX) begin px = 0; ln++; end
    endtask

    task automatic run_pixels(int n, string req);
        for (int k = 0; k < n; k++) one_pixel(req);
    endtask

    task automatic t_reset;
        #1;
        chk(out_valid === 0 && out_sol === 0 && out_sof === 0, "R1 outputs", {out_valid, out_sol, out_sof}, 0);
        chk(out_fill === 0 && underflow === 0, "R1 flags", {out_fill, underflow}, 0);
        chk(eng_ready === '0, "R1 ready", eng_ready, 0);
    endtask

    task automatic t_scanline;
        do_sof(0, 1);
        run_pixels(4 * LINE_PIX, "R3 even/odd");
        @(negedge clk);
        chk(out_valid === 0, "R5 idle no output", out_valid, 0);
    endtask

    task automatic t_bands;
        do_sof(2, 2);
        run_pixels(12 * LINE_PIX, "R2 bands3x3");
    endtask

    task automatic t_tall;
        do_sof(255, 1);
        run_pixels(260 * LINE_PIX, "R2 height256");
    endtask

    task automatic t_32eng;
        do_sof(0, 31);
        run_pixels(34 * LINE_PIX, "R10 wrap32");
    endtask

    task automatic t_cfg_hold;
        do_sof(1, 1);
        run_pixels(2 * LINE_PIX, "R4 before change");
        cfg_band_m1 = 8'd0; cfg_eng_m1 = 5'd3;
        run_pixels(6 * LINE_PIX, "R4 held");
        do_sof(0, 3);
        run_pixels(5 * LINE_PIX, "R4 applied");
    endtask

    task automatic t_restart;
        do_sof(0, 2);
        run_pixels(LINE_PIX + 2, "R9 pre");
        @(negedge clk);
        sof = 1'b1; pix_en = 1'b1;
        #1;
        chk(eng_ready === '0, "R9 R8 ready at sof", eng_ready, 0);
        @(negedge clk);
        sof = 1'b0; pix_en = 1'b0;
        chk(out_valid === 0, "R9 request at sof dropped", out_valid, 0);
        ln = 0; px = 0; first_exp = 1'b1;
        run_pixels(3 * LINE_PIX, "R9 restart");
    endtask

    task automatic t_underflow;
        eng_valid = ~32'h2;
        do_sof(0, 1);
        run_pixels(3 * LINE_PIX, "R7 missing engine1");
        eng_valid = '1;
        do_sof(0, 1);
        run_pixels(2 * LINE_PIX, "R7 sticky");
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_scanline();
        t_bands();
        t_tall();
        t_32eng();
        t_cfg_hold();
        t_restart();
        t_underflow();
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule